// File: doc/BRIEF.md
# Byte-Serial Debug Packet Bridge

This block joins an 8-bit byte-wide debug link to the wide packet ports of an on-chip interconnect. It has two paths that run on their own and may be busy in the same cycle.

On the inbound path, bytes arrive one at a time. Each accepted byte is shifted in at the low end of a packet register. Once eight bytes have been taken, the register is offered to the fabric. Further bytes are refused until the fabric takes the packet. The inbound state machine has two states:

- `IB_FILL` accepts bytes. Transition *fill-complete* moves it to `IB_OFFER` when the eighth byte is taken.
- `IB_OFFER` offers the packet. Transition *packet-taken* returns it to `IB_FILL` and clears the byte counter.

On the outbound path, a wide debug word from a ship is sent as a fixed series of six bytes, least significant first. Each byte is the word shifted right by eight times the byte counter. Only after the last byte has left is the word acknowledged. The outbound state machine has three states:

- `OB_IDLE` waits for a word. Transition *word-arrives* moves it to `OB_SEND`.
- `OB_SEND` emits bytes. Transition *last-byte-sent* moves it to `OB_ACK` once the byte with counter value 5 or more has transferred.
- `OB_ACK` acknowledges the word. Transition *word-released* returns it to `OB_IDLE`.

Every port uses a valid/ready handshake. A transfer happens on a rising clock edge where both valid and ready are high.

Top module: `dbg_byte_bridge`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both byte counters and the packet register. After that edge, `pkt_data` is 0, `pkt_valid`, `tx_valid` and `dw_ready` are low, and `rx_ready` is high.
- R2: Each accepted input byte shifts `pkt_data` left by 8 bits and places the byte in bits [7:0]. Bits pushed above `PKT_W` are discarded. After eight bytes, the first byte sits in bits [63:56] and the last in bits [7:0].
- R3: `rx_ready` is high exactly while fewer than 8 bytes have been accepted since reset or since the last packet transfer. After the eighth byte, `rx_ready` is low and `pkt_valid` is high.
- R4: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and `pkt_data` stays stable. After a packet transfer, `pkt_valid` is low and `rx_ready` is high in the next cycle.
- R5: A byte offered while `rx_ready` is low is ignored. `pkt_data` keeps the finished packet.
- R6: The n-th byte of a word (n = 0..5) on `tx_byte` equals bits [8n+7:8n] of `dw_data`. Bit positions at or above `WORD_W` read as 0, so byte 5 of a 44-bit word carries bits [43:40] in its low nibble.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_byte` stays stable.
- R8: `dw_ready` stays low until six byte transfers of the word have completed. It is high, with `tx_valid` low, in the cycle after the sixth byte transfer. It drops after the word transfer.
- R9: The inbound and outbound paths work correctly when both are active in the same cycles.
- R10: `tx_valid` is low whenever no debug word is pending (`dw_valid` low in the idle state).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Inbound byte |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Bridge can accept a byte |
| pkt_data | output | PKT_W | Assembled packet |
| pkt_valid | output | 1 | Packet offered to fabric |
| pkt_ready | input | 1 | Fabric takes the packet |
| dw_data | input | WORD_W | Debug word from the ship |
| dw_valid | input | 1 | Debug word pending |
| dw_ready | output | 1 | Debug word acknowledge |
| tx_byte | output | 8 | Outbound byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Link takes the byte |

## Verification
Several properties are checked by the assertions on every cycle:

- the handshake holds on `pkt_valid` and `tx_valid`;
- the newest byte lands in bits [7:0] of the packet;
- `rx_ready` is low while a packet is offered;
- the acknowledge never overlaps an outbound byte and lasts only one handshake;
- the first byte of each word is its low byte.

Other behaviours only the bench scenarios can show. These are the full byte order of an assembled packet and the exact shift of every outbound byte, including the zero-filled top of byte 5. They also include that exactly six transfers precede the acknowledge, and that stalls, gaps and concurrent traffic on both paths leave the results intact.

// File: rtl/dbg_byte_bridge_pkg.sv
package dbg_byte_bridge_pkg;

    typedef enum logic [0:0] {
        IB_FILL  = 1'b0,
        IB_OFFER = 1'b1
    } ib_state_e;

    typedef enum logic [1:0] {
        OB_IDLE = 2'd0,
        OB_SEND = 2'd1,
        OB_ACK  = 2'd2
    } ob_state_e;

endpackage

// File: rtl/dbg_bridge_rx.sv
module dbg_bridge_rx
    import dbg_byte_bridge_pkg::*;
#(
    parameter int PKT_W    = 64,
    parameter int IN_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       rx_byte,
    input  logic             rx_valid,
    output logic             rx_ready,
    output logic [PKT_W-1:0] pkt_data,
    output logic             pkt_valid,
    input  logic             pkt_ready
);
    localparam int CNT_W = $clog2(IN_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IN_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(IN_BYTES);

    ib_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PKT_W-1:0] pkt_q;
    logic             take;
    logic             hand;

    assign take = rx_valid && rx_ready;
    assign hand = pkt_valid && pkt_ready;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IB_FILL:  if (take && cnt_q == LAST_IDX) st_d = IB_OFFER; // fill-complete
            IB_OFFER: if (hand) st_d = IB_FILL;                      // packet-taken
            default:  st_d = IB_FILL;
        endcase
    end

    // state register, counter and packet register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= IB_FILL;
            cnt_q <= '0;
            pkt_q <= '0;
        end else begin
            st_q <= st_d;
            if (take) begin
                pkt_q <= {pkt_q[PKT_W-9:0], rx_byte};
                cnt_q <= cnt_q + 1'b1;
            end else if (hand) begin
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        rx_ready  = (st_q == IB_FILL);
        pkt_valid = (st_q == IB_OFFER);
    end
    assign pkt_data = pkt_q;

    AST_RX_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> (pkt_data[7:0] == $past(rx_byte))); // R2
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> !rx_ready); // R3
    AST_RX_CNT_FULL: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (cnt_q == FULL_CNT)); // R3
    AST_PKT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data))); // R4
    AST_PKT_REFILL: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready) |=> (rx_ready && !pkt_valid)); // R4
    AST_RX_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> $stable(pkt_data)); // R5

endmodule

// File: rtl/dbg_bridge_tx.sv
module dbg_bridge_tx
    import dbg_byte_bridge_pkg::*;
#(
    parameter int WORD_W    = 44,
    parameter int OUT_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] dw_data,
    input  logic              dw_valid,
    output logic              dw_ready,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready
);
    localparam int CNT_W = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(OUT_BYTES - 1);

    ob_state_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              send;
    logic              is_last;
    logic [WORD_W-1:0] shifted;

    assign send    = tx_valid && tx_ready;
    assign is_last = (cnt_q >= LAST_IDX);
    assign shifted = dw_data >> {cnt_q, 3'b000};

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OB_IDLE: if (dw_valid) st_d = OB_SEND;          // word-arrives
            OB_SEND: if (send && is_last) st_d = OB_ACK;    // last-byte-sent
            OB_ACK:  if (dw_valid) st_d = OB_IDLE;          // word-released
            default: st_d = OB_IDLE;
        endcase
    end

    // state register and byte counter
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= OB_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (send) cnt_q <= is_last ? '0 : cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_valid = (st_q == OB_SEND);
        dw_ready = (st_q == OB_ACK);
        tx_byte  = shifted[7:0];
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && $stable(dw_data)) |=> (tx_valid && $stable(tx_byte))); // R7
    AST_TX_FIRST_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_byte == dw_data[7:0])); // R6
    AST_ACK_NO_BYTE: assert property (@(posedge clk) disable iff (rst)
        dw_ready |-> !tx_valid); // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (dw_ready && dw_valid) |=> !dw_ready); // R8
    AST_TX_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
        (!tx_valid && !dw_valid && !dw_ready) |=> !tx_valid); // R10

endmodule

// File: rtl/dbg_byte_bridge.sv
module dbg_byte_bridge #(
    parameter int PKT_W     = 64,
    parameter int IN_BYTES  = 8,
    parameter int WORD_W    = 44,
    parameter int OUT_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    input  logic [WORD_W-1:0] dw_data,
    input  logic              dw_valid,
    output logic              dw_ready,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready
);

    dbg_bridge_rx #(
        .PKT_W    (PKT_W),
        .IN_BYTES (IN_BYTES)
    ) rx_i (
        .clk       (clk),
        .rst       (rst),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .pkt_data  (pkt_data),
        .pkt_valid (pkt_valid),
        .pkt_ready (pkt_ready)
    );

    dbg_bridge_tx #(
        .WORD_W    (WORD_W),
        .OUT_BYTES (OUT_BYTES)
    ) tx_i (
        .clk      (clk),
        .rst      (rst),
        .dw_data  (dw_data),
        .dw_valid (dw_valid),
        .dw_ready (dw_ready),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!pkt_valid && !tx_valid && !dw_ready && rx_ready)); // R1

endmodule

// File: tb/dbg_byte_bridge_tb_top.sv
module dbg_byte_bridge_tb_top;
    localparam int PKT_W  = 64;
    localparam int WORD_W = 44;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        rx_byte = '0;
    logic              rx_valid = 1'b0;
    logic              rx_ready;
    logic [PKT_W-1:0]  pkt_data;
    logic              pkt_valid;
    logic              pkt_ready = 1'b0;
    logic [WORD_W-1:0] dw_data = '0;
    logic              dw_valid = 1'b0;
    logic              dw_ready;
    logic [7:0]        tx_byte;
    logic              tx_valid;
    logic              tx_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbg_byte_bridge #(.PKT_W(PKT_W), .IN_BYTES(8), .WORD_W(WORD_W), .OUT_BYTES(6)) dut_i (
        .clk(clk), .rst(rst),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .pkt_data(pkt_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .dw_data(dw_data), .dw_valid(dw_valid), .dw_ready(dw_ready),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // inbound: 8 bytes with gaps, then the packet is held for 'hold' cycles
    task automatic in_packet(input int p, input int gap, input int hold);
        logic [63:0] exp = '0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b = 8'(p * 37 + i * 11 + 5);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                rx_valid = 1'b0;
            end
            @(negedge clk);
            chk(rx_ready == 1'b1, "R3 ready while filling", 64'(rx_ready), 64'd1);
            if (i > 0) chk(pkt_data[7:0] == exp[7:0], "R2 newest byte low", 64'(pkt_data[7:0]), 64'(exp[7:0]));
            rx_valid = 1'b1;
            rx_byte  = b;
            exp = {exp[55:0], b};
        end
        @(negedge clk);
        rx_byte = 8'hEE;  // stays offered while full
        chk(rx_ready == 1'b0, "R3 not ready when full", 64'(rx_ready), 64'd0);
        chk(pkt_valid == 1'b1, "R3 packet offered", 64'(pkt_valid), 64'd1);
        chk(pkt_data == exp, "R2 packet byte order", pkt_data, exp);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(pkt_valid == 1'b1, "R4 packet held", 64'(pkt_valid), 64'd1);
            chk(pkt_data == exp, "R5 ignored byte", pkt_data, exp);
        end
        @(negedge clk);
        chk(pkt_data == exp, "R5 ignored byte", pkt_data, exp);
        pkt_ready = 1'b1;
        rx_valid  = 1'b0;
        @(negedge clk);
        pkt_ready = 1'b0;
        chk(pkt_valid == 1'b0 && rx_ready == 1'b1, "R4 refill after transfer",
            64'({pkt_valid, rx_ready}), 64'b01);
        chk(pkt_data == exp, "R5 packet kept", pkt_data, exp);
    endtask

    // outbound: one word, tx_ready stalled where stall bit is set
    task automatic out_word(input logic [WORD_W-1:0] w, input logic [15:0] stall);
        logic [63:0] wv = 64'(w);
        int n = 0;
        int cyc = 0;
        @(negedge clk);
        dw_data  = w;
        dw_valid = 1'b1;
        while (n < 6 && cyc < 200) begin
            @(negedge clk);
            cyc++;
            chk(dw_ready == 1'b0, "R8 no early ack", 64'(dw_ready), 64'd0);
            if (tx_valid) begin
                logic [7:0] e = 8'(wv >> (8 * n));
                chk(tx_byte == e, "R6/R7 byte value", 64'(tx_byte), 64'(e));
            end
            tx_ready = !stall[cyc % 16];
            if (tx_valid && tx_ready) n++;
        end
        @(negedge clk);
        tx_ready = 1'b0;
        chk(dw_ready == 1'b1 && tx_valid == 1'b0, "R8 ack after sixth byte",
            64'({dw_ready, tx_valid}), 64'b10);
        @(negedge clk);
        dw_valid = 1'b0;
        chk(dw_ready == 1'b0, "R8 ack single", 64'(dw_ready), 64'd0);
        chk(tx_valid == 1'b0, "R10 idle after word", 64'(tx_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pkt_data == '0, "R1 packet cleared", pkt_data, 64'd0);
        chk({pkt_valid, tx_valid, dw_ready, rx_ready} == 4'b0001, "R1 handshakes idle",
            64'({pkt_valid, tx_valid, dw_ready, rx_ready}), 64'b0001);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R10 no word no byte", 64'(tx_valid), 64'd0);
        end
        for (int p = 0; p < 6; p++) in_packet(p, p % 3, p % 4);
        for (int q = 0; q < 8; q++) begin
            logic [WORD_W-1:0] w = WORD_W'(64'h0F1E_2D3C_4B5A * (q + 1) + 64'(q) * 64'h1111);
            out_word(w, 16'(16'h1248 << q));
        end
        out_word({WORD_W{1'b1}}, 16'h0000);
        fork
            in_packet(9, 1, 2);   // R9 concurrent inbound
            out_word(WORD_W'(64'hA5C3_96E1_7F), 16'h0505);
        join
        chk(1'b1, "R9 both paths completed", 64'd1, 64'd1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule